// File: doc/BRIEF.md
# Two-Line Character Scan and Glyph Fetch

This block drives the dot data of a character display with two lines of twenty characters. It walks the character positions in a fixed order. For each position it reads the 8-bit character code from a display memory and converts that code into 5-dot rows, one glyph row at a time. Low codes select one of eight user-defined glyphs kept in a small writable pattern memory. All other codes are decoded by a fixed pattern table. Each dot row leaves the block with a one-cycle strobe and the line, column and glyph-row indices, so a downstream driver can place it.

Both memories sit behind one shared access port. The host uses that port to load character codes and glyph patterns and to read them back. A host access always wins the port. When the host takes it, the scanner holds its position for that cycle, and one output slot stays empty. No character position is dropped or repeated because of this.

Top module: `char_scan_glyph`

## Requirements
- R1: Scan order is line 0 columns 0..19, then line 1 columns 0..19, then back to line 0, forever. Each position emits glyph rows 0..6 in consecutive valid outputs. Glyph row 7 is never emitted.
- R2: Line 0 column c fetches its code from display address c (00h..13h). Line 1 column c fetches from display address 40h+c (40h..53h). No other display address affects the dots.
- R3: dot_sof is high together with dot_valid on the output for line 0, column 0, glyph row 0, and at no other time.
- R4: A code below 10h produces dot_bits equal to the glyph memory byte at address {code[2:0], glyph_row[2:0]}. Codes 08h..0Fh therefore show the same glyphs as 00h..07h.
- R5: Codes from 10h up come from the fixed table. 2Dh gives 1Fh on glyph row 3 and 00h on the other rows. 5Fh gives 1Fh on row 6 only. 7Ch gives 04h on every row. 7Fh gives 1Fh on every row. Codes with no defined glyph, such as 10h, 20h, 80h and FFh, give 00h.
- R6: A clock edge that samples host_req high does not advance the scan, and dot_valid is low after the following edge. An edge that samples host_req low advances the scan, and dot_valid is high after the following edge.
- R7: An edge that samples host_req and host_we high writes host_wdata. With host_sel=0 the write goes to display address host_addr. With host_sel=1 it goes to glyph address host_addr[5:0], and only bits 4:0 are kept.
- R8: An edge that samples host_req high and host_we low raises host_rvalid for one cycle, and host_rdata then holds the addressed byte. Glyph memory reads return 0 in bits 7:5.
- R9: While rst_n is low, dot_valid, dot_sof and host_rvalid are low. The first output after reset is line 0, column 0, glyph row 0, with dot_sof set, two edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host access to the shared port this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = display memory, 1 = glyph memory |
| host_addr | input | 7 | Host address (bits 5:0 used for glyph memory) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data strobe, one edge after a read |
| dot_valid | output | 1 | Dot row strobe |
| dot_sof | output | 1 | First dot row of a frame |
| dot_line | output | 1 | Display line of the dot row |
| dot_col | output | 5 | Column 0..19 of the dot row |
| dot_grow | output | 3 | Glyph row 0..6 |
| dot_bits | output | 5 | Dot pattern, 1 = dot on |

## Verification
The bench fills every display address outside the two scanned windows with the full-block code. A scan that used a contiguous or misplaced line-1 base would then show solid rows where other glyphs are expected. Codes 08h..0Fh and the boundary code 10h are placed on screen. A design that failed to fold the alias, or that let 10h reach the glyph memory, would show the wrong glyph instead of a blank one. Frames are also run with periodic host reads, to catch a scanner that keeps advancing while stalled, which skips positions, or one that leaves a gap at the wrong time. A reset in mid-frame must restart the scan at line 0 with the frame marker.

// File: rtl/char_scan_glyph.sv
module char_scan_glyph #(
  parameter int         COLS       = 20,
  parameter int         GROWS      = 7,
  parameter logic [6:0] LINE2_BASE = 7'h40,
  parameter logic [7:0] USER_LIMIT = 8'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_req,
  input  logic       host_we,
  input  logic       host_sel,
  input  logic [6:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_rvalid,
  output logic       dot_valid,
  output logic       dot_sof,
  output logic       dot_line,
  output logic [4:0] dot_col,
  output logic [2:0] dot_grow,
  output logic [4:0] dot_bits
);

  localparam logic [4:0] COL_LAST  = 5'(COLS - 1);
  localparam logic [2:0] GROW_LAST = 3'(GROWS - 1);

  logic [7:0] dram [0:127];
  logic [4:0] gram [0:63];

  logic       scan_line;
  logic [4:0] scan_col;
  logic [2:0] scan_grow;

  logic       s1_valid, s1_sof, s1_line;
  logic [4:0] s1_col;
  logic [2:0] s1_grow;
  logic [7:0] s1_code;

  wire       scan_go   = !host_req;
  wire [6:0] scan_addr = (scan_line ? LINE2_BASE : 7'h00) + {2'b00, scan_col};
  wire       grow_end  = scan_grow == GROW_LAST;
  wire       col_end   = scan_col == COL_LAST;
  wire       scan_home = !scan_line && scan_col == 5'd0 && scan_grow == 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_line <= 1'b0;
      scan_col  <= '0;
      scan_grow <= '0;
    end else if (scan_go) begin
      if (!grow_end) begin
        scan_grow <= scan_grow + 3'd1;
      end else begin
        scan_grow <= '0;
        if (!col_end) begin
          scan_col <= scan_col + 5'd1;
        end else begin
          scan_col  <= '0;
          scan_line <= ~scan_line;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (host_req && host_we) begin
      if (host_sel) gram[host_addr[5:0]] <= host_wdata[4:0];
      else          dram[host_addr]      <= host_wdata;
    end
    if (scan_go) s1_code <= dram[scan_addr];
    host_rdata <= host_sel ? {3'b000, gram[host_addr[5:0]]} : dram[host_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_sof      <= 1'b0;
      s1_line     <= 1'b0;
      s1_col      <= '0;
      s1_grow     <= '0;
      host_rvalid <= 1'b0;
    end else begin
      s1_valid    <= scan_go;
      s1_sof      <= scan_go && scan_home;
      s1_line     <= scan_line;
      s1_col      <= scan_col;
      s1_grow     <= scan_grow;
      host_rvalid <= host_req && !host_we;
    end
  end

  function automatic logic [4:0] rom_row(input logic [7:0] code, input logic [2:0] r);
    logic [34:0] g;
    case (code)
      8'h2D:   g = {5'h00, 5'h00, 5'h00, 5'h1F, 5'h00, 5'h00, 5'h00};
      8'h30:   g = {5'h0E, 5'h11, 5'h13, 5'h15, 5'h19, 5'h11, 5'h0E};
      8'h31:   g = {5'h04, 5'h0C, 5'h04, 5'h04, 5'h04, 5'h04, 5'h0E};
      8'h41:   g = {5'h0E, 5'h11, 5'h11, 5'h1F, 5'h11, 5'h11, 5'h11};
      8'h42:   g = {5'h1E, 5'h11, 5'h11, 5'h1E, 5'h11, 5'h11, 5'h1E};
      8'h43:   g = {5'h0E, 5'h11, 5'h10, 5'h10, 5'h10, 5'h11, 5'h0E};
      8'h48:   g = {5'h11, 5'h11, 5'h11, 5'h1F, 5'h11, 5'h11, 5'h11};
      8'h5F:   g = {5'h00, 5'h00, 5'h00, 5'h00, 5'h00, 5'h00, 5'h1F};
      8'h7C:   g = {5'h04, 5'h04, 5'h04, 5'h04, 5'h04, 5'h04, 5'h04};
      8'h7F:   g = {5'h1F, 5'h1F, 5'h1F, 5'h1F, 5'h1F, 5'h1F, 5'h1F};
      default: g = '0;
    endcase
    case (r)
      3'd0:    return g[34:30];
      3'd1:    return g[29:25];
      3'd2:    return g[24:20];
      3'd3:    return g[19:15];
      3'd4:    return g[14:10];
      3'd5:    return g[9:5];
      3'd6:    return g[4:0];
      default: return 5'h00;
    endcase
  endfunction

  wire       user_code = s1_code < USER_LIMIT;
  wire [4:0] user_bits = gram[{s1_code[2:0], s1_grow}];
  wire [4:0] rom_bits  = rom_row(s1_code, s1_grow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_valid <= 1'b0;
      dot_sof   <= 1'b0;
      dot_line  <= 1'b0;
      dot_col   <= '0;
      dot_grow  <= '0;
      dot_bits  <= '0;
    end else begin
      dot_valid <= s1_valid;
      dot_sof   <= s1_sof;
      dot_line  <= s1_line;
      dot_col   <= s1_col;
      dot_grow  <= s1_grow;
      dot_bits  <= user_code ? user_bits : rom_bits;
    end
  end

endmodule

// File: rtl/char_scan_glyph_chk.sv
module char_scan_glyph_chk #(
  parameter int COLS  = 20,
  parameter int GROWS = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_req,
  input logic       host_we,
  input logic       host_rvalid,
  input logic       dot_valid,
  input logic       dot_sof,
  input logic       dot_line,
  input logic [4:0] dot_col,
  input logic [2:0] dot_grow
);

  // R3
  sof_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dot_sof |-> dot_valid && !dot_line && dot_col == 5'd0 && dot_grow == 3'd0);

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dot_valid |-> int'(dot_grow) < GROWS && int'(dot_col) < COLS);

  // R1
  grow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dot_valid && $past(dot_valid) && dot_grow != 3'd0 |->
      dot_grow == 3'($past(dot_grow) + 3'd1) && dot_col == $past(dot_col) &&
      dot_line == $past(dot_line));

  // R6
  stall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |=> ##1 !dot_valid);

  // R6
  scan_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req |=> ##1 dot_valid);

  // R8
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && !host_we |=> host_rvalid);

  // R8
  rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_req && !host_we));

endmodule

bind char_scan_glyph char_scan_glyph_chk #(.COLS(COLS), .GROWS(GROWS)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_rvalid(host_rvalid), .dot_valid(dot_valid), .dot_sof(dot_sof),
  .dot_line(dot_line), .dot_col(dot_col), .dot_grow(dot_grow)
);

// File: tb/char_scan_glyph_tb.sv
`timescale 1ns/1ps
module char_scan_glyph_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_req = 1'b0, host_we = 1'b0, host_sel = 1'b0;
  logic [6:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid, dot_valid, dot_sof, dot_line;
  logic [4:0] dot_col, dot_bits;
  logic [2:0] dot_grow;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] bmem [0:127];
  logic [4:0] gmem [0:63];

  always #2 clk = ~clk;

  char_scan_glyph dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .dot_valid(dot_valid),
    .dot_sof(dot_sof), .dot_line(dot_line), .dot_col(dot_col),
    .dot_grow(dot_grow), .dot_bits(dot_bits)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_dots(input logic [7:0] c, input logic [2:0] g);
    if (c < 8'h10) return gmem[{c[2:0], g}];
    case (c)
      8'h2D:   return (g == 3'd3) ? 5'h1F : 5'h00;
      8'h5F:   return (g == 3'd6) ? 5'h1F : 5'h00;
      8'h7C:   return 5'h04;
      8'h7F:   return 5'h1F;
      default: return 5'h00;
    endcase
  endfunction

  function automatic logic [7:0] pick(input int idx, input bit alt);
    logic [7:0] la [10] = '{8'h00, 8'h0F, 8'h2D, 8'h5F, 8'h7C, 8'h7F, 8'h20, 8'h80, 8'h0B, 8'hFF};
    logic [7:0] lb [10] = '{8'h10, 8'h08, 8'h07, 8'h7F, 8'h2D, 8'hFF, 8'h0E, 8'h5F, 8'h80, 8'h7C};
    return alt ? lb[(idx * 3 + 1) % 10] : la[idx % 10];
  endfunction

  task automatic host_write(input bit sel, input logic [6:0] a, input logic [7:0] d);
    host_req = 1'b1; host_we = 1'b1; host_sel = sel; host_addr = a; host_wdata = d;
    if (sel) gmem[a[5:0]] = d[4:0];
    else     bmem[a] = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read(input bit sel, input logic [6:0] a, input logic [7:0] exp,
                           input string req);
    host_req = 1'b1; host_we = 1'b0; host_sel = sel; host_addr = a;
    @(negedge clk);
    host_req = 1'b0;
    chk(host_rvalid == 1'b1, "R8", "rvalid", int'(host_rvalid), 1);
    chk(host_rdata == exp, req, "rdata", int'(host_rdata), int'(exp));
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!dot_valid && !dot_sof && !host_rvalid, "R9", "outputs in reset",
        int'({dot_valid, dot_sof, host_rvalid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dot_valid, "R9", "valid one edge after release", int'(dot_valid), 0);
    @(negedge clk);
    chk(dot_valid && dot_sof && !dot_line && dot_col == 0 && dot_grow == 0, "R9",
        "first output after reset", int'({dot_valid, dot_sof, dot_line, dot_col, dot_grow}),
        int'({1'b1, 1'b1, 1'b0, 5'd0, 3'd0}));
  endtask

  task automatic load_glyphs();
    for (int a = 0; a < 64; a++)
      host_write(1'b1, 7'(a), {3'b111, 5'((a * 7 + 3) & 31)});
  endtask

  task automatic load_codes(input bit alt);
    for (int a = 0; a < 128; a++) host_write(1'b0, 7'(a), 8'h7F);
    for (int ln = 0; ln < 2; ln++)
      for (int c = 0; c < 20; c++)
        host_write(1'b0, 7'((ln != 0 ? 8'h40 : 8'h00) + c), pick(ln * 20 + c, alt));
  endtask

  task automatic test_host_rw();
    host_write(1'b0, 7'h60, 8'h5A);
    host_read(1'b0, 7'h60, 8'h5A, "R7");
    host_write(1'b1, 7'h2A, 8'hF5);
    host_read(1'b1, 7'h2A, 8'h15, "R7");
    host_read(1'b1, 7'h05, {3'b000, gmem[5]}, "R8");
    host_read(1'b0, 7'h41, bmem[7'h41], "R8");
    host_write(1'b0, 7'h61, 8'hC3);
    host_read(1'b0, 7'h61, 8'hC3, "R7");
    @(negedge clk);
    chk(!host_rvalid, "R8", "rvalid single cycle", int'(host_rvalid), 0);
  endtask

  task automatic run_frame(input int period);
    bit h1 = 1'b0, h2 = 1'b0, rq;
    int n = 0, cyc = 0;
    logic el = 1'b0;
    logic [4:0] ec = '0;
    logic [2:0] eg = '0;
    logic [7:0] code;
    logic [4:0] ed;
    host_req = 1'b0;
    do @(negedge clk); while (!(dot_valid && dot_sof));
    while (n < 280) begin
      chk(dot_valid == !h2, "R6", "valid vs stall", int'(dot_valid), int'(!h2));
      if (dot_valid) begin
        chk({dot_line, dot_col, dot_grow} == {el, ec, eg}, "R1", "scan position",
            int'({dot_line, dot_col, dot_grow}), int'({el, ec, eg}));
        chk(dot_sof == (n == 0), "R3", "frame marker", int'(dot_sof), int'(n == 0));
        code = bmem[7'((el ? 8'h40 : 8'h00) + ec)];
        ed = exp_dots(code, eg);
        if (code < 8'h10)
          chk(dot_bits == ed, "R4 (R2 addr)", "user glyph dots", int'(dot_bits), int'(ed));
        else
          chk(dot_bits == ed, "R5 (R2 addr)", "table glyph dots", int'(dot_bits), int'(ed));
        n++;
        if (eg != 3'd6) eg = eg + 3'd1;
        else begin
          eg = '0;
          if (ec != 5'd19) ec = ec + 5'd1;
          else begin ec = '0; el = ~el; end
        end
      end
      rq = (period > 0) && (cyc % period == period - 1);
      host_req = rq; host_we = 1'b0; host_sel = cyc[0]; host_addr = 7'(cyc);
      h2 = h1; h1 = rq; cyc++;
      @(negedge clk);
    end
    host_req = 1'b0;
  endtask

  initial begin
    test_reset();
    load_glyphs();
    load_codes(1'b0);
    test_host_rw();
    run_frame(0);
    run_frame(5);
    load_codes(1'b1);
    run_frame(3);
    run_frame(0);
    repeat (37) @(negedge clk);
    test_reset();
    run_frame(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R1 run did not finish actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule